// File: doc/BRIEF.md
# Transfer Descriptor Status Updater

This block produces the control/status word that a host controller writes back into a USB transfer descriptor after a bus transaction ends. Each input item carries the descriptor's old control word, its token word and the transaction outcome. The outcome is a result code plus a returned byte count. From the token the block decodes the packet fields: PID, device address, endpoint and maximum length. From the outcome it derives the new control word and a set of side flags. The frame-abort flag tells the frame walker to stop the current frame. The hold flag tells the walker not to advance the queue element pointer. The error strobe requests the transaction-error status bit, and the process-error strobe requests the controller-process-error status bit. A two-bit interrupt contribution is also produced.

The block works as a single pipeline stage with valid/ready on both sides. An input item is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result is presented on the outputs from the next cycle onward, with `out_valid` high. The result stays frozen until a cycle in which `out_ready` is high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so an input item can be accepted every cycle while the consumer keeps up. `in_ready` does not depend on `in_valid`.

Result codes on `in_result` are: 0 = acknowledged data, 1 = stall, 2 = NAK, 3 = babble, 4 = timeout/CRC. Codes 5 to 7 are reserved.

Top module: `td_status_updater`

## Requirements
- R1: The token is decoded with the PID in bits 7:0, the device address in bits 14:8 and the endpoint in bits 18:15. These are presented on `out_pid`, `out_dev_addr` and `out_endp`.
- R2: The maximum length is (token bits 31:21 plus one), kept to 11 bits. An encoded 0x7FF therefore gives a maximum of 0, and 7 gives 8.
- R3: On an acknowledged result, the control bits 10:0 become (byte count − 1) kept to 11 bits, so a count of 0 gives 0x7FF. Active (bit 23) and NAK (bit 19) are both cleared.
- R4: For an IN token (PID 0x69), an acknowledged byte count above the maximum length is handled as babble. The length field and the clearing of active and NAK happen as in R3. In addition, babble (bit 20) and stall (bit 22) are set and frame-abort is raised. No interrupt bits are produced.
- R5: On an acknowledged result with short-packet detect (bit 29) set and a count below the maximum, the block sets interrupt bit 1 and raises the hold flag. Without bit 29, or with a count equal to the maximum, neither is produced.
- R6: On an acknowledged, non-babble result with interrupt-on-complete (bit 24) set, the block sets interrupt bit 0. This can happen together with R5.
- R7: A stall result sets bit 22 and clears bit 23. Reserved result codes 5 to 7 are handled the same way.
- R8: A babble result sets bits 20 and 22, clears bit 23, raises frame-abort and leaves the length field unchanged.
- R9: A NAK result on an IN or OUT token sets bit 19 and leaves bit 23 and the error counter unchanged.
- R10: A NAK result on a SETUP token (PID 0x2D) sets bit 19 and then follows the timeout path of R11 and R12.
- R11: On a timeout result, bit 18 is set. A non-zero error counter (bits 28:27) is decremented and written back. When the counter reaches zero, bit 23 is cleared and the error strobe is raised.
- R12: On a timeout with an error counter of zero at entry, the counter stays zero, bit 23 is left unchanged and no error strobe is raised.
- R13: If the PID is not SETUP 0x2D, IN 0x69 or OUT 0xE1, the control word passes through unchanged. Both the process-error strobe and frame-abort are raised, and no other flag is raised.
- R14: A result is held stable on the outputs while `out_valid` is high and `out_ready` is low. After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input item valid |
| in_ready | output | 1 | Block can take an input item |
| in_ctrl | input | 32 | Old descriptor control/status word |
| in_token | input | 32 | Descriptor token word |
| in_result | input | 3 | Transaction result code |
| in_len | input | LEN_W | Byte count returned by the transaction |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_ctrl | output | 32 | New control/status word |
| out_abort | output | 1 | Stop processing the current frame |
| out_hold | output | 1 | Do not advance the queue element pointer |
| out_err | output | 1 | Transaction error status strobe |
| out_proc_err | output | 1 | Process error status strobe (bad PID) |
| out_int_mask | output | 2 | Interrupt contribution: bit 0 on-complete, bit 1 short packet |
| out_pid | output | 8 | Decoded PID |
| out_dev_addr | output | 7 | Decoded device address |
| out_endp | output | 4 | Decoded endpoint |
| out_max_len | output | 11 | Decoded maximum length |

## Verification
The bench targets the points where the rules interact:
- **Zero-byte transfer.** A design that does not wrap the length field would report 0 instead of 0x7FF.
- **Encoded maximum of 0x7FF.** A design that does not wrap the maximum-length decode would report 0x800 truncated wrongly, or 2048.
- **IN count one above the maximum.** A design that misses the babble promotion would report a clean completion with no frame-abort.
- **NAK on SETUP.** A design that treats it like any other NAK would leave the counter and the active bit untouched.
- **Timeout countdown and zero counter.** The bench drives timeouts with counters of 3, 1 and 0, which separates a correct countdown from one that wraps zero to 3 or retires the descriptor one step early.
- **Short-packet boundary.** The bench checks a count exactly equal to the maximum and a short count with bit 29 clear, both of which must produce no hold.

Output back-pressure is applied in a repeating pattern so that held results must stay intact until they are consumed.

// File: rtl/tdsu_pkg.sv
package tdsu_pkg;
  localparam int CW = 32;
  localparam int MLW = 11;

  // control word bit positions
  localparam int B_TMO   = 18;
  localparam int B_NAK   = 19;
  localparam int B_BAB   = 20;
  localparam int B_STALL = 22;
  localparam int B_ACT   = 23;
  localparam int B_IOC   = 24;
  localparam int B_SPD   = 29;
  localparam int B_ERRLO = 27;

  localparam logic [2:0] RES_ACK     = 3'd0;
  localparam logic [2:0] RES_STALL   = 3'd1;
  localparam logic [2:0] RES_NAK     = 3'd2;
  localparam logic [2:0] RES_BABBLE  = 3'd3;
  localparam logic [2:0] RES_TIMEOUT = 3'd4;

  localparam logic [7:0] PID_SETUP = 8'h2D;
  localparam logic [7:0] PID_IN    = 8'h69;
  localparam logic [7:0] PID_OUT   = 8'hE1;

  typedef struct packed {
    logic [7:0]     pid;
    logic [6:0]     addr;
    logic [3:0]     endp;
    logic [MLW-1:0] max_len;
  } tok_t;

  typedef struct packed {
    logic [CW-1:0] ctrl;
    logic          abort;
    logic          hold;
    logic          err;
    logic          perr;
    logic [1:0]    mask;
  } upd_t;
endpackage

// File: rtl/tdsu_token_decode.sv
module tdsu_token_decode
  import tdsu_pkg::*;
(
  input  logic [CW-1:0] token,
  output tok_t          fields
);
  logic [MLW-1:0] enc_len;

  always_comb begin
    enc_len        = token[31:21];
    fields.pid     = token[7:0];
    fields.addr    = token[14:8];
    fields.endp    = token[18:15];
    fields.max_len = enc_len + MLW'(1);
  end
endmodule

// File: rtl/tdsu_status_calc.sv
module tdsu_status_calc
  import tdsu_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic [CW-1:0]    ctrl,
  input  tok_t             tok,
  input  logic [2:0]       result,
  input  logic [LEN_W-1:0] len,
  output upd_t             upd
);
  localparam int PADW = LEN_W - MLW;

  logic             pid_ok, is_in, is_setup;
  logic [LEN_W-1:0] len_m1;
  logic [LEN_W-1:0] max_wide;
  logic [1:0]       cnt;
  logic             do_timeout;

  always_comb begin
    is_in    = (tok.pid == PID_IN);
    is_setup = (tok.pid == PID_SETUP);
    pid_ok   = is_in || is_setup || (tok.pid == PID_OUT);
    len_m1   = len - LEN_W'(1);
    max_wide = {{PADW{1'b0}}, tok.max_len};

    upd      = '0;
    upd.ctrl = ctrl;
    do_timeout = 1'b0;
    cnt      = ctrl[B_ERRLO+1:B_ERRLO];

    if (!pid_ok) begin
      upd.perr  = 1'b1;
      upd.abort = 1'b1;
    end else begin
      case (result)
        RES_ACK: begin
          upd.ctrl[MLW-1:0] = len_m1[MLW-1:0];
          upd.ctrl[B_ACT]   = 1'b0;
          upd.ctrl[B_NAK]   = 1'b0;
          if (is_in && (len > max_wide)) begin
            upd.ctrl[B_BAB]   = 1'b1;
            upd.ctrl[B_STALL] = 1'b1;
            upd.abort         = 1'b1;
          end else begin
            upd.mask[0] = ctrl[B_IOC];
            if (ctrl[B_SPD] && (len < max_wide)) begin
              upd.mask[1] = 1'b1;
              upd.hold    = 1'b1;
            end
          end
        end
        RES_NAK: begin
          upd.ctrl[B_NAK] = 1'b1;
          do_timeout      = is_setup;
        end
        RES_TIMEOUT: do_timeout = 1'b1;
        RES_BABBLE: begin
          upd.ctrl[B_BAB]   = 1'b1;
          upd.ctrl[B_STALL] = 1'b1;
          upd.ctrl[B_ACT]   = 1'b0;
          upd.abort         = 1'b1;
        end
        default: begin
          upd.ctrl[B_STALL] = 1'b1;
          upd.ctrl[B_ACT]   = 1'b0;
        end
      endcase

      if (do_timeout) begin
        upd.ctrl[B_TMO] = 1'b1;
        if (cnt != 2'd0) begin
          upd.ctrl[B_ERRLO+1:B_ERRLO] = cnt - 2'd1;
          if (cnt == 2'd1) begin
            upd.ctrl[B_ACT] = 1'b0;
            upd.err         = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/td_status_updater.sv
module td_status_updater
  import tdsu_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_ctrl,
  input  logic [31:0]      in_token,
  input  logic [2:0]       in_result,
  input  logic [LEN_W-1:0] in_len,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_ctrl,
  output logic             out_abort,
  output logic             out_hold,
  output logic             out_err,
  output logic             out_proc_err,
  output logic [1:0]       out_int_mask,
  output logic [7:0]       out_pid,
  output logic [6:0]       out_dev_addr,
  output logic [3:0]       out_endp,
  output logic [10:0]      out_max_len
);
  tok_t tok_c, tok_q;
  upd_t upd_c, upd_q;
  logic vld_q;

  tdsu_token_decode u_dec (.token(in_token), .fields(tok_c));

  tdsu_status_calc #(.LEN_W(LEN_W)) u_calc (
    .ctrl(in_ctrl), .tok(tok_c), .result(in_result), .len(in_len), .upd(upd_c)
  );

  assign in_ready = !vld_q || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      tok_q <= '0;
      upd_q <= '0;
    end else if (in_valid && in_ready) begin
      vld_q <= 1'b1;
      tok_q <= tok_c;
      upd_q <= upd_c;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid    = vld_q;
  assign out_ctrl     = upd_q.ctrl;
  assign out_abort    = upd_q.abort;
  assign out_hold     = upd_q.hold;
  assign out_err      = upd_q.err;
  assign out_proc_err = upd_q.perr;
  assign out_int_mask = upd_q.mask;
  assign out_pid      = tok_q.pid;
  assign out_dev_addr = tok_q.addr;
  assign out_endp     = tok_q.endp;
  assign out_max_len  = tok_q.max_len;
endmodule

// File: rtl/tdsu_checker.sv
module tdsu_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_ctrl,
  input logic        out_abort,
  input logic        out_hold,
  input logic        out_err,
  input logic        out_proc_err,
  input logic [1:0]  out_int_mask
);
  // R14
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_ctrl) && $stable(out_int_mask)
      && $stable(out_abort) && $stable(out_hold) && $stable(out_err) && $stable(out_proc_err));

  // R14
  accept_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R13
  perr_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_proc_err |-> out_abort && !out_err && !out_hold && out_int_mask == 2'b00);

  // R11
  err_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> !out_ctrl[23] && out_ctrl[18] && out_ctrl[28:27] == 2'b00);

  // R5
  hold_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_hold |-> out_int_mask[1] && out_ctrl[29] && !out_ctrl[23]);

  // R8
  abort_babble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_abort && !out_proc_err |-> out_ctrl[20] && out_ctrl[22] && !out_ctrl[23]);
endmodule

bind td_status_updater tdsu_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_ctrl(out_ctrl),
  .out_abort(out_abort), .out_hold(out_hold), .out_err(out_err),
  .out_proc_err(out_proc_err), .out_int_mask(out_int_mask)
);

// File: tb/tb_td_status_updater.sv
module tb_td_status_updater;
  localparam int LW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [31:0] in_ctrl = '0, in_token = '0;
  logic [2:0] in_result = '0;
  logic [LW-1:0] in_len = '0;
  logic out_valid, out_ready = 1'b1;
  logic [31:0] out_ctrl;
  logic out_abort, out_hold, out_err, out_proc_err;
  logic [1:0] out_int_mask;
  logic [7:0] out_pid;
  logic [6:0] out_dev_addr;
  logic [3:0] out_endp;
  logic [10:0] out_max_len;

  always #10 clk = ~clk;

  td_status_updater #(.LEN_W(LW)) dut (.*);

  typedef struct packed {
    logic [31:0] ctrl;
    logic abort, hold, err, perr;
    logic [1:0] mask;
    logic [7:0] pid;
    logic [6:0] addr;
    logic [3:0] ep;
    logic [10:0] mx;
  } exp_t;

  exp_t q[$];
  string tagq[$];
  int checks = 0, fails = 0;
  int cyc = 0;
  bit done = 0;

  function automatic logic [31:0] mk_tok(logic [7:0] pid, logic [6:0] a, logic [3:0] e, logic [10:0] mlc);
    return {mlc, 2'b00, e, a, pid};
  endfunction

  // reference built from the requirement list
  function automatic exp_t model(logic [31:0] c, logic [31:0] t, logic [2:0] r, logic [LW-1:0] n);
    exp_t x;
    logic [10:0] mx;
    logic [1:0] k;
    logic tmo;
    x = '0;
    mx = t[31:21] + 11'd1;
    x.pid = t[7:0]; x.addr = t[14:8]; x.ep = t[18:15]; x.mx = mx;
    x.ctrl = c;
    tmo = 0;
    if (!(t[7:0] == 8'h2D || t[7:0] == 8'h69 || t[7:0] == 8'hE1)) begin
      x.perr = 1; x.abort = 1;
      return x;
    end
    if (r == 3'd0) begin
      x.ctrl[10:0] = 11'(n - 1);
      x.ctrl[23] = 0; x.ctrl[19] = 0;
      if (t[7:0] == 8'h69 && n > LW'(mx)) begin
        x.ctrl[20] = 1; x.ctrl[22] = 1; x.abort = 1;
      end else begin
        x.mask[0] = c[24];
        if (c[29] && n < LW'(mx)) begin x.mask[1] = 1; x.hold = 1; end
      end
    end else if (r == 3'd2) begin
      x.ctrl[19] = 1;
      tmo = (t[7:0] == 8'h2D);
    end else if (r == 3'd4) begin
      tmo = 1;
    end else if (r == 3'd3) begin
      x.ctrl[20] = 1; x.ctrl[22] = 1; x.ctrl[23] = 0; x.abort = 1;
    end else begin
      x.ctrl[22] = 1; x.ctrl[23] = 0;
    end
    if (tmo) begin
      x.ctrl[18] = 1;
      k = c[28:27];
      if (k != 0) begin
        x.ctrl[28:27] = k - 1;
        if (k == 1) begin x.ctrl[23] = 0; x.err = 1; end
      end
    end
    return x;
  endfunction

  task automatic send(string tag, logic [31:0] c, logic [31:0] t, logic [2:0] r, logic [LW-1:0] n);
    in_ctrl = c; in_token = t; in_result = r; in_len = n; in_valid = 1'b1;
    q.push_back(model(c, t, r, n));
    tagq.push_back(tag);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // back-pressure pattern, changed away from the sampling edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 out_ready <= ((cyc % 5) != 3) && ((cyc % 13) != 7);
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && !done) begin
      exp_t a, e;
      string tg;
      a = {out_ctrl, out_abort, out_hold, out_err, out_proc_err, out_int_mask,
           out_pid, out_dev_addr, out_endp, out_max_len};
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R14: unexpected output actual=%h expected=none", a);
      end else begin
        e = q.pop_front();
        tg = tagq.pop_front();
        if (a !== e) begin
          fails++;
          $display("FAIL %s: actual=%h expected=%h", tg, a, e);
        end
      end
    end
  end

  localparam logic [31:0] BASE = 32'h1880_0000; // active, counter 3

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++; // R14 reset state
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R14: reset actual=%b%b expected=01", out_valid, in_ready);
    end
    // R1 decode fields
    send("R1", BASE, mk_tok(8'h69, 7'h55, 4'hA, 11'd7), 3'd0, 12'd8);
    send("R1", BASE, mk_tok(8'hE1, 7'h7F, 4'hF, 11'd1), 3'd0, 12'd2);
    // R2 max length wrap
    send("R2", BASE, mk_tok(8'hE1, 7'h01, 4'h1, 11'h7FF), 3'd0, 12'd0);
    // R3 success: length encoding, NAK/active cleared, zero-length
    send("R3", BASE | 32'h0008_0000, mk_tok(8'hE1, 7'h02, 4'h3, 11'd63), 3'd0, 12'd64);
    send("R3", BASE, mk_tok(8'h2D, 7'h02, 4'h0, 11'd7), 3'd0, 12'd8);
    send("R3", BASE, mk_tok(8'h69, 7'h02, 4'h0, 11'd7), 3'd0, 12'd0);
    // R4 IN overrun by one, and OUT with same count (no promotion)
    send("R4", BASE, mk_tok(8'h69, 7'h03, 4'h2, 11'd7), 3'd0, 12'd9);
    send("R4", BASE, mk_tok(8'hE1, 7'h03, 4'h2, 11'd7), 3'd0, 12'd9);
    // R5 short packet, equal length, SPD clear
    send("R5", BASE | 32'h2000_0000, mk_tok(8'h69, 7'h04, 4'h1, 11'd7), 3'd0, 12'd3);
    send("R5", BASE | 32'h2000_0000, mk_tok(8'h69, 7'h04, 4'h1, 11'd7), 3'd0, 12'd8);
    send("R5", BASE, mk_tok(8'h69, 7'h04, 4'h1, 11'd7), 3'd0, 12'd3);
    // R6 interrupt on complete, alone and with short packet
    send("R6", BASE | 32'h0100_0000, mk_tok(8'hE1, 7'h05, 4'h1, 11'd7), 3'd0, 12'd8);
    send("R6", BASE | 32'h2100_0000, mk_tok(8'h69, 7'h05, 4'h1, 11'd7), 3'd0, 12'd1);
    // R7 stall and reserved codes
    send("R7", BASE, mk_tok(8'h69, 7'h06, 4'h1, 11'd7), 3'd1, 12'd0);
    send("R7", BASE, mk_tok(8'hE1, 7'h06, 4'h1, 11'd7), 3'd6, 12'd0);
    // R8 babble result
    send("R8", BASE | 32'h0000_0123, mk_tok(8'h69, 7'h07, 4'h1, 11'd7), 3'd3, 12'd4);
    // R9 NAK on IN and OUT
    send("R9", BASE, mk_tok(8'h69, 7'h08, 4'h1, 11'd7), 3'd2, 12'd0);
    send("R9", 32'h0880_0000, mk_tok(8'hE1, 7'h08, 4'h1, 11'd7), 3'd2, 12'd0);
    // R10 NAK on SETUP, counter 3 and 1
    send("R10", BASE, mk_tok(8'h2D, 7'h09, 4'h0, 11'd7), 3'd2, 12'd0);
    send("R10", 32'h0880_0000, mk_tok(8'h2D, 7'h09, 4'h0, 11'd7), 3'd2, 12'd0);
    // R11 countdown 3->2, 2->1, 1->0
    send("R11", BASE, mk_tok(8'h69, 7'h0A, 4'h2, 11'd7), 3'd4, 12'd0);
    send("R11", 32'h1080_0000, mk_tok(8'h69, 7'h0A, 4'h2, 11'd7), 3'd4, 12'd0);
    send("R11", 32'h0880_0000, mk_tok(8'h69, 7'h0A, 4'h2, 11'd7), 3'd4, 12'd0);
    // R12 zero counter
    send("R12", 32'h0080_0000, mk_tok(8'hE1, 7'h0B, 4'h2, 11'd7), 3'd4, 12'd0);
    // R13 invalid PID
    send("R13", BASE | 32'h2100_0005, mk_tok(8'h00, 7'h0C, 4'h3, 11'd7), 3'd4, 12'd0);
    send("R13", BASE, mk_tok(8'hA5, 7'h0C, 4'h3, 11'd7), 3'd0, 12'd9);
    // R14 back-to-back under back-pressure
    for (int i = 0; i < 20; i++)
      send("R14", BASE ^ (32'(i) << 24), mk_tok(8'h69, 7'(i), 4'(i), 11'(i)), 3'(i % 5), LW'(i));
    for (int i = 0; i < 200 && q.size() != 0; i++) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R14: pending actual=%0d expected=0", q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL R14: watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule